// File: doc/BRIEF.md
# Per-Port Ingress Byte Rate Limiter

This block polices the frames arriving on one switch port. Time is split into fixed measurement windows of `WIN_CYCLES` clock cycles, nominally one second. Within each window it keeps a count of admitted bytes for each of two traffic classes. When a frame starts, the block decides whether the frame fits in what is left of its class budget. If it fits, the frame is admitted and its length is charged. If it does not fit, the frame is refused. A frame is judged only once, at its start, and an admitted frame is never cut short.

Each class budget is a 12-bit limit, counted in units of 4096 bytes per window. At a one-second window, one unit is 32 kbps, so the usable range runs from zero up to line rate. A 12-bit limit is usually written through an 8-bit and a 4-bit register field; that assembly sits outside this block, which receives the full 12-bit value. When class separation is enabled, high-priority frames draw on their own counter and limit. When it is disabled, all traffic shares the low-class counter and limit. A global enable turns policing off while the counters keep running.

Frame starts arrive as a valid/ready descriptor stream carrying the length and a priority flag. Decisions leave as a valid/ready stream holding one accept bit. The block holds one decision. It accepts a new descriptor only when that slot is empty, or when the slot is being emptied in the same cycle. A decision that is not taken stays on the outputs, unchanged.

Top module: `rl_policer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `dec_valid` is 0 and `in_ready` is 1. Both class counters start at zero and the window counter starts at its first cycle.
- R2: The window restarts every `WIN_CYCLES` cycles, counted from reset release. On the last cycle of each window, both class counters clear. A descriptor taken in that last cycle is judged against an empty counter and is charged to the new window.
- R3: The budget of a class is its limit multiplied by 4096 bytes. With policing enabled, a frame is accepted exactly when the bytes already charged in this window plus its length do not exceed the budget, so a frame that lands exactly on the budget is accepted.
- R4: An accepted frame adds its length to its class counter. A refused frame adds nothing, so a later, shorter frame in the same window can still be accepted.
- R5: With `prio_en` = 1, a frame with `in_hi` = 1 is judged and charged against `lim_hi` and the high counter. A frame with `in_hi` = 0 uses `lim_lo` and the low counter. Traffic in one class never changes the decisions for the other class.
- R6: With `prio_en` = 0, `in_hi` has no effect: every frame uses `lim_lo` and the low counter.
- R7: With `en` = 0, every frame is accepted and its length is still charged. If policing is enabled again within the same window, the bytes charged while it was off count toward the budget.
- R8: A limit of 0 refuses every frame of nonzero length in that class, and accepts a zero-length frame.
- R9: `in_ready` = !`dec_valid` || `dec_ready`. A descriptor taken at a clock edge produces `dec_valid` = 1 in the next cycle, with its verdict on `dec_accept` (1 = admit, 0 = drop). While `dec_valid` = 1 and `dec_ready` = 0, `dec_valid` and `dec_accept` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Policing enable; 0 admits all frames |
| prio_en | input | 1 | 1 = separate high/low class budgets |
| lim_hi | input | LIM_W (12) | High-class limit, units of 4096 bytes per window |
| lim_lo | input | LIM_W (12) | Low-class (or shared) limit, units of 4096 bytes per window |
| in_valid | input | 1 | Frame-start descriptor valid |
| in_ready | output | 1 | Descriptor can be taken this cycle |
| in_len | input | LEN_W (11) | Frame length in bytes |
| in_hi | input | 1 | Frame priority, 1 = high |
| dec_valid | output | 1 | Decision available |
| dec_ready | input | 1 | Decision consumer ready |
| dec_accept | output | 1 | 1 = admit frame, 0 = drop |

## Verification
On every cycle, the assertions check the stream rules: a decision follows one cycle after each taken descriptor, and a stalled decision holds still. They also check that an idle decision slot is empty after reset, that the window tick has a fixed period, that the disabled mode always admits, and that a zero limit refuses frames of nonzero length. The budget arithmetic can only be shown by the bench's scenarios, which its reference model tracks byte by byte. Those scenarios cover acceptance exactly at the budget, refusals that leave room for later frames, isolation between classes, the shared class when separation is off, bytes charged while policing is off, and a frame that lands on the window boundary.

// File: rtl/rl_pkg.sv
package rl_pkg;
  // traffic classes, also used as the index of the per-class meters
  typedef enum logic {
    CLS_LO = 1'b0,
    CLS_HI = 1'b1
  } rl_cls_e;

  localparam int NUM_CLS     = 2;
  // one limit step equals 2**BLOCK_SHIFT bytes per window
  localparam int BLOCK_SHIFT = 12;

  // a registered verdict waiting for its consumer
  typedef struct packed {
    logic valid;
    logic accept;
  } rl_dec_t;
endpackage

// File: rtl/rl_window_timer.sv
module rl_window_timer #(
  parameter int WIN_CYCLES = 125_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

  logic [CW-1:0] phase_q;

  assign tick = (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (tick) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/rl_byte_meter.sv
module rl_byte_meter #(
  parameter int LEN_W = 11,
  parameter int LIM_W = 12,
  parameter int CNT_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_clr,
  input  logic             police,
  input  logic [LIM_W-1:0] limit,
  input  logic [LEN_W-1:0] len,
  input  logic             take,
  output logic             fits
);
  import rl_pkg::*;

  localparam int SUM_W = CNT_W + 1;
  localparam int BUD_W = LIM_W + BLOCK_SHIFT;

  logic [CNT_W-1:0] used_q;
  logic [CNT_W-1:0] base;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] budget;
  logic [CNT_W-1:0] sum_sat;

  // window start wins over the old count in the same cycle
  assign base    = win_clr ? '0 : used_q;
  assign sum     = {1'b0, base} + {{(SUM_W-LEN_W){1'b0}}, len};
  assign budget  = {{(SUM_W-BUD_W){1'b0}}, limit, {BLOCK_SHIFT{1'b0}}};
  assign fits    = !police || (sum <= budget);
  assign sum_sat = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q <= '0;
    end else if (take && fits) begin
      used_q <= sum_sat;
    end else begin
      used_q <= base;
    end
  end
endmodule

// File: rtl/rl_decision_reg.sv
module rl_decision_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic verdict,
  output logic fire,
  output logic dec_valid,
  input  logic dec_ready,
  output logic dec_accept
);
  import rl_pkg::*;

  rl_dec_t slot_q;

  assign in_ready   = !slot_q.valid || dec_ready;
  assign fire       = in_valid && in_ready;
  assign dec_valid  = slot_q.valid;
  assign dec_accept = slot_q.accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (fire) begin
      slot_q.valid  <= 1'b1;
      slot_q.accept <= verdict;
    end else if (dec_ready) begin
      slot_q.valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/rl_policer.sv
module rl_policer #(
  parameter int WIN_CYCLES = 125_000_000,
  parameter int LEN_W      = 11,
  parameter int LIM_W      = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             prio_en,
  input  logic [LIM_W-1:0] lim_hi,
  input  logic [LIM_W-1:0] lim_lo,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [LEN_W-1:0] in_len,
  input  logic             in_hi,
  output logic             dec_valid,
  input  logic             dec_ready,
  output logic             dec_accept
);
  import rl_pkg::*;

  localparam int CNT_W = LIM_W + BLOCK_SHIFT + 1;

  logic                win_tick;
  logic                fire;
  logic                verdict;
  rl_cls_e             cls;
  logic [NUM_CLS-1:0]  fits_v;
  logic [LIM_W-1:0]    lim_v [NUM_CLS];

  assign cls      = (prio_en && in_hi) ? CLS_HI : CLS_LO;
  assign lim_v[0] = lim_lo;
  assign lim_v[1] = lim_hi;
  assign verdict  = fits_v[cls];

  rl_window_timer #(
    .WIN_CYCLES(WIN_CYCLES)
  ) u_win (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (win_tick)
  );

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_meter
    rl_byte_meter #(
      .LEN_W(LEN_W),
      .LIM_W(LIM_W),
      .CNT_W(CNT_W)
    ) u_meter (
      .clk    (clk),
      .rst_n  (rst_n),
      .win_clr(win_tick),
      .police (en),
      .limit  (lim_v[c]),
      .len    (in_len),
      .take   (fire && (cls == rl_cls_e'(c))),
      .fits   (fits_v[c])
    );
  end

  rl_decision_reg u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .verdict   (verdict),
    .fire      (fire),
    .dec_valid (dec_valid),
    .dec_ready (dec_ready),
    .dec_accept(dec_accept)
  );
endmodule

// File: rtl/rl_policer_chk.sv
module rl_policer_chk #(
  parameter int WIN_CYCLES = 125_000_000,
  parameter int LEN_W      = 11,
  parameter int LIM_W      = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             prio_en,
  input logic [LIM_W-1:0] lim_hi,
  input logic [LIM_W-1:0] lim_lo,
  input logic             in_valid,
  input logic             in_ready,
  input logic [LEN_W-1:0] in_len,
  input logic             in_hi,
  input logic             dec_valid,
  input logic             dec_ready,
  input logic             dec_accept,
  input logic             win_tick
);
  localparam int CW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

  logic [CW-1:0]    ref_phase;
  logic             taken;
  logic [LIM_W-1:0] sel_lim;

  assign taken   = in_valid && in_ready;
  assign sel_lim = (prio_en && in_hi) ? lim_hi : lim_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) ref_phase <= '0;
    else if (ref_phase == LAST) ref_phase <= '0;
    else ref_phase <= ref_phase + 1'b1;
  end

  // R1
  reset_empty_chk: assert property (@(posedge clk) !rst_n |=> !dec_valid);

  // R2
  window_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_tick == (ref_phase == LAST));

  // R9
  verdict_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> dec_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_accept)));

  // R9
  no_drop_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_valid && !taken) |=> !dec_valid);

  // R7
  bypass_admit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !en) |=> dec_accept);

  // R8
  zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && en && sel_lim == '0 && in_len != '0) |=> !dec_accept);
endmodule

bind rl_policer rl_policer_chk #(
  .WIN_CYCLES(WIN_CYCLES),
  .LEN_W     (LEN_W),
  .LIM_W     (LIM_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .prio_en   (prio_en),
  .lim_hi    (lim_hi),
  .lim_lo    (lim_lo),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_len    (in_len),
  .in_hi     (in_hi),
  .dec_valid (dec_valid),
  .dec_ready (dec_ready),
  .dec_accept(dec_accept),
  .win_tick  (win_tick)
);

// File: tb/sim_rl_policer.sv
`timescale 1ns/1ps
module sim_rl_policer;
  localparam int WIN   = 64;
  localparam int LEN_W = 11;
  localparam int LIM_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, prio_en = 1'b0;
  logic [LIM_W-1:0] lim_hi = '0, lim_lo = '0;
  logic in_valid = 1'b0, in_hi = 1'b0, dec_ready = 1'b1;
  logic [LEN_W-1:0] in_len = '0;
  logic in_ready, dec_valid, dec_accept;

  int vectors = 0, errors = 0;
  bit done = 0;
  bit toggle_rdy = 0;
  string stage = "R1";

  // reference model state
  int     m_wc = 0;
  longint m_used [2];
  bit     m_dv = 0, m_acc = 0;

  always #2 clk = ~clk;

  rl_policer #(.WIN_CYCLES(WIN), .LEN_W(LEN_W), .LIM_W(LIM_W)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .prio_en(prio_en),
    .lim_hi(lim_hi), .lim_lo(lim_lo),
    .in_valid(in_valid), .in_ready(in_ready), .in_len(in_len), .in_hi(in_hi),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_accept(dec_accept));

  always @(posedge clk) begin
    bit tick, fire, pass;
    int c;
    longint lim;
    if (!rst_n) begin
      m_wc = 0; m_used[0] = 0; m_used[1] = 0; m_dv = 0; m_acc = 0;
    end else begin
      tick = (m_wc == WIN - 1);
      if (tick) begin m_used[0] = 0; m_used[1] = 0; end
      fire = in_valid && (!m_dv || dec_ready);
      if (fire) begin
        c    = (prio_en && in_hi) ? 1 : 0;
        lim  = (c == 1) ? longint'(lim_hi) : longint'(lim_lo);
        pass = !en || (m_used[c] + in_len <= lim * 4096);
        if (pass) m_used[c] += in_len;
        m_dv = 1; m_acc = pass;
      end else if (dec_ready) begin
        m_dv = 0;
      end
      m_wc = tick ? 0 : m_wc + 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (in_ready !== (!m_dv || dec_ready)) begin
        errors++;
        $display("FAIL %s in_ready act=%b exp=%b t=%0t", stage, in_ready, !m_dv || dec_ready, $time);
      end
      vectors++;
      if (dec_valid !== m_dv) begin
        errors++;
        $display("FAIL %s dec_valid act=%b exp=%b t=%0t", stage, dec_valid, m_dv, $time);
      end
      if (m_dv) begin
        vectors++;
        if (dec_accept !== m_acc) begin
          errors++;
          $display("FAIL %s dec_accept act=%b exp=%b t=%0t", stage, dec_accept, m_acc, $time);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (toggle_rdy) begin
      #1 dec_ready = ($urandom_range(0, 2) != 0);
    end
  end

  task automatic send(input int len, input bit hi);
    @(negedge clk); #1;
    in_valid = 1'b1; in_len = LEN_W'(len); in_hi = hi;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk); #1; in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // return at the negedge where the model phase equals v
  task automatic wait_wc(input int v);
    @(negedge clk); #1; in_valid = 1'b0;
    while (m_wc != v) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R4: shared budget of 4096 bytes, equality at the edge
    stage = "R3"; lim_lo = 12'd1; wait_wc(WIN - 1);
    send(1500, 0); send(1500, 0); send(1500, 0);
    stage = "R4"; send(1096, 0); send(1, 0); send(0, 0);
    idle(2);

    // R5: high class has its own counter and limit
    stage = "R5"; prio_en = 1'b1; lim_hi = 12'd2; lim_lo = 12'd1; wait_wc(WIN - 1);
    for (int i = 0; i < 6; i++) send(2000, 1);
    send(2000, 0); send(2000, 0); send(2000, 0);
    idle(2);

    // R6: in_hi ignored when class separation is off
    stage = "R6"; prio_en = 1'b0; wait_wc(WIN - 1);
    send(2000, 1); send(2000, 1); send(2000, 0); send(96, 1);
    idle(2);

    // R7: bytes charged while policing is off count afterwards
    stage = "R7"; wait_wc(WIN - 1); en = 1'b0;
    send(2047, 0); send(2047, 0); send(2047, 1);
    @(negedge clk); #1 en = 1'b1; in_valid = 1'b0;
    send(1, 0); send(2, 0);
    idle(2);

    // R8: zero limit
    stage = "R8"; lim_lo = 12'd0; wait_wc(WIN - 1);
    send(64, 0); send(0, 0); send(1, 0);
    idle(2);

    // R2: frame in the last window cycle is charged to the new window
    stage = "R2"; lim_lo = 12'd1; wait_wc(WIN - 8);
    send(2000, 0); send(2000, 0);
    wait_wc(WIN - 2);
    send(4000, 0); send(96, 0); send(1, 0);
    idle(WIN + 3);

    // R9: stalled consumer
    stage = "R9"; lim_lo = 12'd3; prio_en = 1'b1; lim_hi = 12'd1;
    toggle_rdy = 1'b1;
    for (int i = 0; i < 40; i++) send(300 + 97 * i, i[0]);
    idle(4);
    toggle_rdy = 1'b0; #1 dec_ready = 1'b1;
    idle(4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule